// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM

This block drives two pulse-width-modulated outputs. Each channel's waveform is described by two 16-bit counts: the number of prescaled ticks spent high, followed by the number spent low. A period is therefore the sum of the two counts, and the duty cycle is the high share. Both counts for a channel sit together in one 32-bit count register. One shared control register holds both channels' enables and their clock-path settings.

Each channel has its own clock path. A two-bit field picks one of four tick-strobe inputs. A 7-bit prescaler then divides that tick rate. A gate bit lets the prescaled ticks reach the phase counter or holds them back. The tick inputs are single-cycle clock-enable strobes in the block's clock domain. Software writes counts and control through a simple 32-bit register port. Turning a channel off pulls its output low at once, without letting the current period finish.

Top module: `dual_phase_pwm`

## Requirements
- R1: After reset every register reads zero and both outputs are low.
- R2: Offset 0x0 is channel 0's count register and offset 0x4 is channel 1's. In each, bits 31:16 give the high-phase count and bits 15:0 give the low-phase count. Both read back exactly what was written.
- R3: Offset 0x8 is the control register. It reads back its stored fields, and its unused bits (3:2 and 31:24) read as zero. For channel c (0 or 1), the fields are:
  - enable at bit c;
  - source select at bits 5:4 for channel 0 and 7:6 for channel 1;
  - prescaler value at bits 14:8 for channel 0 and 22:16 for channel 1;
  - gate at bit 15 for channel 0 and bit 23 for channel 1.
- R4: A write to any offset other than 0x0, 0x4 or 0x8 changes no register, and reads from such offsets return zero.
- R5: While enabled and gated, the output is high for the high count of prescaled ticks, then low for the low count of prescaled ticks, and repeats. Enabling starts a period in the high phase on the clock after the enable is stored, unless the high count is 0.
- R6: The source select value n makes the channel count strobes from tick input n.
- R7: A prescaler value p lets one in every p+1 selected strobes through, so 0 passes every strobe.
- R8: While the gate bit is clear, the channel's phase does not advance and its output holds its level. Setting the gate again resumes counting.
- R9: A low count of 0 with a non-zero high count gives a constantly high output.
- R10: A high count of 0 gives a constantly low output, and so does a pair of zero counts.
- R11: Clearing a channel's enable drives its output low on the next clock and clears its phase. When the channel is enabled again, it starts afresh in the high phase with the current counts.
- R12: Count register writes made while a channel runs take effect at the next period boundary, that is, after the current low phase ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| srcTick | input | 4 | Four tick-strobe sources, one-cycle pulses |
| pwmOut | output | 2 | Channel outputs, bit c is channel c |

## Verification
The hardest case to reach from the ports is a count-register write that lands in the middle of a running period. The old counts must govern the rest of that period, including its low phase, before the new ones appear. The stimulus waits until the output has just risen, writes new counts two clocks later, and then checks the lengths of the next four recorded high/low runs. A similar timed write clears the enable in the middle of a long high phase. This shows that the output stays high until the stored enable reaches the channel and drops on exactly the next clock. The table sweep uses sources with different strobe spacings, so that the select and the prescaler multiply into distinct run lengths.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int NUM_CH     = 2;
  localparam int NUM_SRC    = 4;
  localparam int SEL_W      = $clog2(NUM_SRC);
  localparam int DIV_W      = 7;
  localparam int CNT_W      = 16;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;

  // register map: count registers are strided, control register follows
  localparam int CNT_STRIDE = 4;
  localparam int CTRL_OFS   = CNT_STRIDE * NUM_CH;

  // control field placement (per-channel strides)
  localparam int SEL_BASE   = 4;
  localparam int DIV_BASE   = 8;
  localparam int DIV_STRIDE = 8;
  localparam int HI_LSB     = DATA_W - CNT_W;

  // strobes handed from the control side to each channel datapath
  typedef struct packed {
    logic             enable;
    logic             tick;
    logic [CNT_W-1:0] hiCnt;
    logic [CNT_W-1:0] loCnt;
  } chanStrobe_t;

endpackage

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl
  import dpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic [DATA_W-1:0] regRdata,
  output chanStrobe_t       chanStb [NUM_CH]
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

  logic              ctrlHit;
  logic [DATA_W-1:0] cntView  [NUM_CH];
  logic              enView   [NUM_CH];
  logic              gateView [NUM_CH];
  logic [SEL_W-1:0]  selView  [NUM_CH];
  logic [DIV_W-1:0]  divView  [NUM_CH];
  logic [DATA_W-1:0] rdCtrl;
  logic              unusedWdata;

  assign ctrlHit     = regWr && (regAddr == CTRL_ADDR);
  assign unusedWdata = ^{regWdata[3:2], regWdata[31:24]};

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(CNT_STRIDE * c);
    localparam int EN_BIT   = c;
    localparam int SEL_LSB  = SEL_BASE + SEL_W * c;
    localparam int DIV_LSB  = DIV_BASE + DIV_STRIDE * c;
    localparam int GATE_BIT = DIV_LSB + DIV_W;

    logic              cntHit;
    logic [DATA_W-1:0] cntQ;
    logic              enQ;
    logic              gateQ;
    logic [SEL_W-1:0]  selQ;
    logic [DIV_W-1:0]  divQ;
    logic [DIV_W-1:0]  preCnt;
    logic              srcSel;
    logic              preHit;
    logic              tick;

    assign cntHit = regWr && (regAddr == CNT_ADDR);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (cntHit) begin
        cntQ <= regWdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ   <= 1'b0;
        gateQ <= 1'b0;
        selQ  <= '0;
        divQ  <= '0;
      end else if (ctrlHit) begin
        enQ   <= regWdata[EN_BIT];
        gateQ <= regWdata[GATE_BIT];
        selQ  <= regWdata[SEL_LSB +: SEL_W];
        divQ  <= regWdata[DIV_LSB +: DIV_W];
      end
    end

    // prescaler: counts selected strobes, emits one tick per divQ+1 strobes
    assign srcSel = srcTick[selQ];
    assign preHit = (preCnt >= divQ);
    assign tick   = gateQ && srcSel && preHit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        preCnt <= '0;
      end else if (!gateQ) begin
        preCnt <= '0;
      end else if (srcSel) begin
        if (preHit) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end

    assign cntView[c]  = cntQ;
    assign enView[c]   = enQ;
    assign gateView[c] = gateQ;
    assign selView[c]  = selQ;
    assign divView[c]  = divQ;

    assign chanStb[c].enable = enQ;
    assign chanStb[c].tick   = tick;
    assign chanStb[c].hiCnt  = cntQ[HI_LSB +: CNT_W];
    assign chanStb[c].loCnt  = cntQ[CNT_W-1:0];
  end

  always_comb begin
    rdCtrl = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      rdCtrl[c]                                      = enView[c];
      rdCtrl[SEL_BASE + SEL_W * c +: SEL_W]          = selView[c];
      rdCtrl[DIV_BASE + DIV_STRIDE * c +: DIV_W]     = divView[c];
      rdCtrl[DIV_BASE + DIV_STRIDE * c + DIV_W]      = gateView[c];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_ADDR) begin
      regRdata = rdCtrl;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (regAddr == ADDR_W'(CNT_STRIDE * c)) begin
        regRdata = cntView[c];
      end
    end
  end

endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan
  import dpwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  chanStrobe_t stb,
  output logic        pwmOut
);

  logic             running;
  logic             inHigh;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] curHi;
  logic [CNT_W-1:0] curLo;
  logic [CNT_W-1:0] curLen;
  logic [CNT_W:0]   nextCnt;
  logic             phaseEnd;
  logic             newHiNz;

  assign curLen   = inHigh ? curHi : curLo;
  assign nextCnt  = {1'b0, phaseCnt} + 1'b1;
  assign phaseEnd = (nextCnt >= {1'b0, curLen});
  assign newHiNz  = (stb.hiCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      inHigh   <= 1'b0;
      phaseCnt <= '0;
      curHi    <= '0;
      curLo    <= '0;
    end else if (!stb.enable) begin
      running  <= 1'b0;
      inHigh   <= 1'b0;
      phaseCnt <= '0;
    end else if (!running) begin
      running  <= 1'b1;
      curHi    <= stb.hiCnt;
      curLo    <= stb.loCnt;
      inHigh   <= newHiNz;
      phaseCnt <= '0;
    end else if (stb.tick) begin
      if (!phaseEnd) begin
        phaseCnt <= nextCnt[CNT_W-1:0];
      end else if (inHigh && (curLo != '0)) begin
        inHigh   <= 1'b0;
        phaseCnt <= '0;
      end else begin
        // period boundary: adopt the latest counts
        curHi    <= stb.hiCnt;
        curLo    <= stb.loCnt;
        inHigh   <= newHiNz;
        phaseCnt <= '0;
      end
    end
  end

  assign pwmOut = inHigh;

endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
  import dpwm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_SRC-1:0]  srcTick,
  output logic [NUM_CH-1:0]   pwmOut
);

  chanStrobe_t chanStb [NUM_CH];

  dpwm_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .srcTick  (srcTick),
    .regRdata (regRdata),
    .chanStb  (chanStb)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    dpwm_chan chan_i (
      .clk    (clk),
      .rstN   (rstN),
      .stb    (chanStb[c]),
      .pwmOut (pwmOut[c])
    );
  end

endmodule

// File: rtl/dual_phase_pwm_chk.sv
module dual_phase_pwm_chk
  import dpwm_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                regWr,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWdata,
  input logic [DATA_W-1:0]   regRdata,
  input logic [NUM_CH-1:0]   pwmOut
);

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

  // shadow of enable and gate bits, rebuilt from the write port
  logic [NUM_CH-1:0] shEn;
  logic [NUM_CH-1:0] shEnD1;
  logic [NUM_CH-1:0] shGate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shEn   <= '0;
      shEnD1 <= '0;
      shGate <= '0;
    end else begin
      shEnD1 <= shEn;
      if (regWr && regAddr == ADDR_W'(CTRL_OFS)) begin
        for (int c = 0; c < NUM_CH; c++) begin
          shEn[c]   <= regWdata[c];
          shGate[c] <= regWdata[DIV_BASE + DIV_STRIDE * c + DIV_W];
        end
      end
    end
  end

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(regAddr inside {4'h0, 4'h4, 4'h8}) |-> regRdata == '0); // R4

  AST_CNT0_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWr) && $past(regAddr) == 4'h0 && regAddr == 4'h0 |-> regRdata == $past(regWdata)); // R2

  AST_CNT1_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWr) && $past(regAddr) == 4'h4 && regAddr == 4'h4 |-> regRdata == $past(regWdata)); // R2

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWr) && $past(regAddr) == 4'h8 && regAddr == 4'h8 |-> regRdata == ($past(regWdata) & CTRL_MASK)); // R3

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWr) && $stable(regAddr) |-> $stable(regRdata)); // R4

  for (genvar c = 0; c < NUM_CH; c++) begin : gAst
    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
      !shEn[c] |=> !pwmOut[c]); // R11

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      shEn[c] && shEnD1[c] && !shGate[c] |=> $stable(pwmOut[c])); // R8
  end

endmodule

bind dual_phase_pwm dual_phase_pwm_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .pwmOut   (pwmOut)
);

// File: tb/dual_phase_pwm_tb_top.sv
`timescale 1ns/1ps
module dual_phase_pwm_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  srcTick = '0;
  logic [1:0]  pwmOut;

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;

  always #2.5 clk = ~clk;

  dual_phase_pwm dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .srcTick(srcTick), .pwmOut(pwmOut)
  );

  // source n strobes once every n+1 cycles
  initial begin
    forever begin
      @(posedge clk);
      cyc <= cyc + 1;
      for (int i = 0; i < 4; i++) srcTick[i] <= ((cyc + 1) % (i + 1)) == 0;
    end
  end

  // run-length recorder per channel
  int   runLen [2][256];
  logic runVal [2][256];
  int   runIdx [2] = '{0, 0};
  int   curRun [2] = '{0, 0};
  logic prevOut [2] = '{1'b0, 1'b0};

  always @(negedge clk) begin
    for (int ch = 0; ch < 2; ch++) begin
      if (pwmOut[ch] === prevOut[ch]) begin
        curRun[ch] = curRun[ch] + 1;
      end else begin
        runLen[ch][runIdx[ch] % 256] = curRun[ch];
        runVal[ch][runIdx[ch] % 256] = prevOut[ch];
        runIdx[ch] = runIdx[ch] + 1;
        prevOut[ch] = pwmOut[ch];
        curRun[ch] = 1;
      end
    end
  end

  typedef struct packed {
    logic [0:0]  ch;
    logic [1:0]  sel;
    logic [6:0]  div;
    logic [15:0] hi;
    logic [15:0] lo;
    logic [15:0] expHi;
    logic [15:0] expLo;
  } vec_t;

  // expected run = count * (div+1) * (sel+1) cycles
  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 7'd0, 16'd3, 16'd5, 16'd3,  16'd5},
    '{1'b0, 2'd1, 7'd0, 16'd2, 16'd2, 16'd4,  16'd4},
    '{1'b1, 2'd2, 7'd1, 16'd3, 16'd1, 16'd18, 16'd6},
    '{1'b1, 2'd3, 7'd2, 16'd1, 16'd4, 16'd12, 16'd48},
    '{1'b0, 2'd0, 7'd4, 16'd2, 16'd3, 16'd10, 16'd15},
    '{1'b1, 2'd0, 7'd0, 16'd1, 16'd1, 16'd1,  16'd1},
    '{1'b0, 2'd3, 7'd0, 16'd1, 16'd2, 16'd4,  16'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic waitRuns(input int ch, input int target);
    int t = 0;
    while (runIdx[ch] < target && t < 5000) begin
      @(negedge clk);
      #1;
      t++;
    end
    if (t >= 5000) chk("run wait timeout", runIdx[ch], target);
  endtask

  function automatic logic [31:0] mkCtrl(input int ch, input logic en,
      input logic [1:0] sel, input logic [6:0] dv, input logic gate);
    logic [31:0] w = '0;
    w[ch]              = en;
    w[4 + 2*ch +: 2]   = sel;
    w[8 + 8*ch +: 7]   = dv;
    w[15 + 8*ch]       = gate;
    return w;
  endfunction

  int count;

  initial begin
    logic [31:0] d;
    int base;
    int hiLen;
    int loLen;
    logic v;

    // reset, R1
    tickN(5);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R1 outputs", pwmOut, 0);
    rd(4'h0, d); chk("R1 cnt0", d, 0);
    rd(4'h4, d); chk("R1 cnt1", d, 0);
    rd(4'h8, d); chk("R1 ctrl", d, 0);

    // register readback, R2 R3
    wr(4'h0, 32'h1234_5678); rd(4'h0, d); chk("R2 cnt0 readback", d, 32'h1234_5678);
    wr(4'h4, 32'hABCD_0001); rd(4'h4, d); chk("R2 cnt1 readback", d, 32'hABCD_0001);
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, d); chk("R3 ctrl readback", d, 32'h00FF_FFF3);
    wr(4'h8, 32'h0);

    // undefined offsets, R4
    wr(4'hC, 32'hDEAD_BEEF);
    rd(4'hC, d); chk("R4 undef read", d, 0);
    rd(4'h0, d); chk("R4 cnt0 untouched", d, 32'h1234_5678);
    rd(4'h4, d); chk("R4 cnt1 untouched", d, 32'hABCD_0001);
    rd(4'h8, d); chk("R4 ctrl untouched", d, 0);

    // table sweep: R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      int ch;
      ch = int'(VECS[i].ch);
      wr(4'h8, 32'h0);
      wr(4'(4 * ch), {VECS[i].hi, VECS[i].lo});
      wr(4'h8, mkCtrl(ch, 1'b1, VECS[i].sel, VECS[i].div, 1'b1));
      tickN(1);
      chk("R5 starts high", pwmOut[ch], 1);
      base = runIdx[ch];
      waitRuns(ch, base + 4);
      hiLen = 0; loLen = 0;
      for (int k = 2; k < 4; k++) begin
        if (runVal[ch][(base + k) % 256]) hiLen = runLen[ch][(base + k) % 256];
        else loLen = runLen[ch][(base + k) % 256];
      end
      chk($sformatf("R5 R6 R7 vec%0d high run", i), hiLen, int'(VECS[i].expHi));
      chk($sformatf("R5 R6 R7 vec%0d low run", i), loLen, int'(VECS[i].expLo));
    end

    // mid-period update, R12
    wr(4'h8, 32'h0);
    wr(4'h0, {16'd10, 16'd10});
    wr(4'h8, mkCtrl(0, 1'b1, 2'd0, 7'd0, 1'b1));
    count = 0;
    while (pwmOut[0] !== 1'b0 && count < 100) begin tickN(1); count++; end
    while (pwmOut[0] !== 1'b1 && count < 100) begin tickN(1); count++; end
    base = runIdx[0];
    tickN(2);
    wr(4'h0, {16'd4, 16'd6});
    waitRuns(0, base + 4);
    chk("R12 current high keeps old", runLen[0][base % 256], 10);
    chk("R12 current low keeps old", runLen[0][(base + 1) % 256], 10);
    chk("R12 next high uses new", runLen[0][(base + 2) % 256], 4);
    chk("R12 next low uses new", runLen[0][(base + 3) % 256], 6);

    // gate hold, R8
    wr(4'h8, mkCtrl(0, 1'b1, 2'd0, 7'd0, 1'b0));
    v = pwmOut[0];
    count = 0;
    for (int k = 0; k < 30; k++) begin
      tickN(1);
      if (pwmOut[0] !== v) count++;
    end
    chk("R8 no change while gate clear", count, 0);
    wr(4'h8, mkCtrl(0, 1'b1, 2'd0, 7'd0, 1'b1));
    count = 0;
    for (int k = 0; k < 20; k++) begin
      tickN(1);
      if (pwmOut[0] !== v) count++;
    end
    chk("R8 resumes when gate set", count > 0, 1);

    // immediate disable and fresh restart, R11
    wr(4'h8, 32'h0);
    wr(4'h0, {16'd20, 16'd5});
    wr(4'h8, mkCtrl(0, 1'b1, 2'd0, 7'd0, 1'b1));
    tickN(2);
    wr(4'h8, 32'h0);
    chk("R11 high until enable reaches channel", pwmOut[0], 1);
    tickN(1);
    chk("R11 low on next clock", pwmOut[0], 0);
    count = 0;
    for (int k = 0; k < 10; k++) begin
      tickN(1);
      if (pwmOut[0] !== 1'b0) count++;
    end
    chk("R11 stays low while disabled", count, 0);
    wr(4'h0, {16'd5, 16'd5});
    wr(4'h8, mkCtrl(0, 1'b1, 2'd0, 7'd0, 1'b1));
    tickN(1);
    count = 0;
    while (pwmOut[0] === 1'b1 && count < 50) begin count++; tickN(1); end
    chk("R11 restart full high phase", count, 5);

    // constant high, R9
    wr(4'h8, 32'h0);
    wr(4'h4, {16'd3, 16'd0});
    wr(4'h8, mkCtrl(1, 1'b1, 2'd0, 7'd0, 1'b1));
    tickN(3);
    count = 0;
    for (int k = 0; k < 40; k++) begin
      tickN(1);
      if (pwmOut[1] !== 1'b1) count++;
    end
    chk("R9 constant high", count, 0);

    // constant low, R10
    wr(4'h8, 32'h0);
    wr(4'h4, {16'd0, 16'd4});
    wr(4'h8, mkCtrl(1, 1'b1, 2'd0, 7'd0, 1'b1));
    count = 0;
    for (int k = 0; k < 40; k++) begin
      tickN(1);
      if (pwmOut[1] !== 1'b0) count++;
    end
    chk("R10 high count zero stays low", count, 0);
    wr(4'h4, 32'h0);
    tickN(10);
    count = 0;
    for (int k = 0; k < 40; k++) begin
      tickN(1);
      if (pwmOut[1] !== 1'b0) count++;
    end
    chk("R10 both zero stays low", count, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule